// File: doc/BRIEF.md
# Linked-Descriptor Word DMA Channel

This block moves 16-bit words between a byte-addressed memory port and a peripheral word stream. The work is given as a chain of descriptors held in memory. Each descriptor has four 32-bit words: a byte count, a control word carrying a last-in-chain flag, a buffer address, and the address of the following descriptor. Software loads the address of the first descriptor into a pointer register and then issues a start command that also selects the direction. In the receive direction, words taken from the stream are written into memory. In the transmit direction, words are read from memory and offered on the stream.

The channel fetches a descriptor and then steps through its buffer in 2-byte words. When the buffer is finished, the channel either follows the next pointer or stops if the descriptor is marked last. On stopping it raises a one-cycle completion pulse and a sticky interrupt flag. A reset command abandons any transfer in progress, including a pending memory request, and returns the channel to idle. Software can poll the busy output until the channel is idle.

The byte-count field is `LEN_W` bits wide, and a value of zero stands for the largest possible buffer. Since every transfer is a whole word, an odd count moves one extra byte.

Top module: `dmac_chain`

## Requirements
- R1: After `rst_n` is released, `busy`, `done`, `irq`, `mem_req`, `in_ready` and `out_valid` are all 0.
- R2: A `sw_start` pulse while idle begins a run. The run uses the pointer last loaded through `sw_first_we`, and `sw_dir_rx` (1 = receive, 0 = transmit) sets the direction. The descriptor words are read at pointer+0 (byte count), +4 (control), +8 (buffer address) and +12 (next pointer), in that order. While busy, `sw_start` and new pointer writes have no effect on the current run.
- R3: The memory port has at most one request open at a time. `mem_req` stays high with `mem_addr` and `mem_we` unchanged until the cycle in which `mem_ack` is high, and that cycle completes the access.
- R4: Only bits [LEN_W-1:0] of the byte-count word are used. A field value of 0 means 2^LEN_W bytes.
- R5: An odd byte count is rounded up by one, so a buffer of N bytes moves ceil(N/2) words and no halfword past that is written.
- R6: In receive, each word accepted on `in_data` (in the cycle where `in_valid` and `in_ready` are both high) is written with `mem_we`=1. The words go to successive halfword addresses, starting at the buffer address and stepping by 2, in arrival order.
- R7: In transmit, halfwords are read from the buffer address stepping by 2, and each word is taken from `mem_rdata[15:0]`. Each word is shown on `out_data` with `out_valid` held until `out_ready` is high.
- R8: When a buffer is finished and bit 0 of its control word is 0, the next descriptor is fetched from the address in that descriptor's next-pointer word.
- R9: When a buffer is finished and bit 0 of its control word is 1, the channel goes idle without reading further descriptors. It pulses `done` for exactly one cycle and sets `irq`, which stays set until a reset command.
- R10: A `sw_reset` pulse overrides everything else. The channel is idle in the next cycle with `irq` cleared and no memory request, and a later start works normally.
- R11: While idle, `mem_req`, `in_ready` and `out_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_first_we | input | 1 | Load the first-descriptor pointer |
| sw_first_ptr | input | 32 | First-descriptor byte address |
| sw_start | input | 1 | Start command (accepted only when idle) |
| sw_dir_rx | input | 1 | Direction of the run: 1 receive, 0 transmit |
| sw_reset | input | 1 | Reset command: abort and go idle |
| busy | output | 1 | Channel is running |
| done | output | 1 | One-cycle pulse when the last descriptor completes |
| irq | output | 1 | Sticky completion flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Completes the open request |
| in_valid | input | 1 | Receive stream word valid |
| in_data | input | 16 | Receive stream word |
| in_ready | output | 1 | Channel accepts a receive word |
| out_valid | output | 1 | Transmit stream word valid |
| out_data | output | 16 | Transmit stream word |
| out_ready | input | 1 | Sink accepts the transmit word |

## Verification
The assertions check the following on every cycle:
- a memory request is held unchanged until it is acknowledged;
- a start from idle opens a descriptor read;
- the reset command leaves the channel idle with the flag cleared;
- the completion pulse lasts one cycle and coincides with the flag and with idle;
- the remaining count is always even;
- the ports stay quiet while idle.

Other behaviour can only be shown by the bench scenarios, because it depends on memory contents and sequences:
- that every word reaches the right halfword address in the right order;
- the exact sequence of descriptor and buffer addresses read as the chain is followed;
- the zero-means-maximum byte count, and the round-up of odd counts with the halfword beyond left untouched;
- that a second start during a run is ignored;
- recovery after a mid-transfer reset.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int AW        = 32;
    localparam int DW        = 16;
    localparam int MAX_LEN_W = 16;
    localparam int REM_W     = MAX_LEN_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_RX_GET = 3'd2,
        ST_RX_PUT = 3'd3,
        ST_TX_GET = 3'd4,
        ST_TX_PUT = 3'd5
    } dmac_st_e;

    typedef struct packed {
        dmac_st_e             st;
        logic [1:0]           widx;
        logic [AW-1:0]        first_ptr;
        logic [AW-1:0]        cur_ptr;
        logic [AW-1:0]        buf_addr;
        logic [AW-1:0]        next_ptr;
        logic [MAX_LEN_W-1:0] len_raw;
        logic                 eol;
        logic [REM_W-1:0]     rem;
        logic [DW-1:0]        hold;
        logic                 rx;
        logic                 done;
        logic                 irq;
    } dmac_regs_t;
endpackage

// File: rtl/dmac_len_dec.sv
module dmac_len_dec #(
    parameter int LEN_W = 16
) (
    input  logic [LEN_W-1:0]           raw,
    output logic [dmac_pkg::REM_W-1:0] bytes
);
    localparam int RW = dmac_pkg::REM_W;

    // zero selects the full range; odd counts round up to a whole word
    always_comb begin
        if (raw == '0) begin
            bytes = RW'(1) << LEN_W;
        end else begin
            bytes = RW'(raw) + RW'(raw[0]);
        end
    end
endmodule

// File: rtl/dmac_port_mux.sv
module dmac_port_mux
    import dmac_pkg::*;
(
    input  dmac_st_e        st,
    input  logic [1:0]      widx,
    input  logic [AW-1:0]   cur_ptr,
    input  logic [AW-1:0]   buf_addr,
    input  logic [DW-1:0]   hold,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            in_ready,
    output logic            out_valid,
    output logic [DW-1:0]   out_data
);
    always_comb begin
        mem_req   = (st == ST_FETCH) || (st == ST_RX_PUT) || (st == ST_TX_GET);
        mem_we    = (st == ST_RX_PUT);
        mem_addr  = (st == ST_FETCH) ? (cur_ptr + {{(AW-4){1'b0}}, widx, 2'b00}) : buf_addr;
        mem_wdata = hold;
        in_ready  = (st == ST_RX_GET);
        out_valid = (st == ST_TX_PUT);
        out_data  = hold;
    end
endmodule

// File: rtl/dmac_chain.sv
module dmac_chain
    import dmac_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_first_we,
    input  logic [31:0]   sw_first_ptr,
    input  logic          sw_start,
    input  logic          sw_dir_rx,
    input  logic          sw_reset,
    output logic          busy,
    output logic          done,
    output logic          irq,
    output logic          mem_req,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          in_valid,
    input  logic [15:0]   in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [15:0]   out_data,
    input  logic          out_ready
);
    localparam logic [REM_W-1:0] WORD_BYTES = REM_W'(2);

    dmac_regs_t       q, n;
    logic             adv;
    logic [REM_W-1:0] dec_bytes;

    dmac_len_dec #(.LEN_W(LEN_W)) u_len (
        .raw   (q.len_raw[LEN_W-1:0]),
        .bytes (dec_bytes)
    );

    dmac_port_mux u_mux (
        .st        (q.st),
        .widx      (q.widx),
        .cur_ptr   (q.cur_ptr),
        .buf_addr  (q.buf_addr),
        .hold      (q.hold),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always_comb begin
        n      = q;
        n.done = 1'b0;
        adv    = 1'b0;
        if (sw_first_we) begin
            n.first_ptr = sw_first_ptr;
        end
        if (sw_reset) begin
            n.st  = ST_IDLE;
            n.irq = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: begin
                    if (sw_start) begin
                        n.st      = ST_FETCH;
                        n.widx    = 2'd0;
                        n.cur_ptr = q.first_ptr;
                        n.rx      = sw_dir_rx;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        n.widx = q.widx + 2'd1;
                        case (q.widx)
                            2'd0: n.len_raw  = MAX_LEN_W'(mem_rdata[LEN_W-1:0]);
                            2'd1: n.eol      = mem_rdata[0];
                            2'd2: n.buf_addr = mem_rdata;
                            default: begin
                                n.next_ptr = mem_rdata;
                                n.rem      = dec_bytes;
                                n.st       = q.rx ? ST_RX_GET : ST_TX_GET;
                            end
                        endcase
                    end
                end
                ST_RX_GET: begin
                    if (in_valid) begin
                        n.hold = in_data;
                        n.st   = ST_RX_PUT;
                    end
                end
                ST_RX_PUT: adv = mem_ack;
                ST_TX_GET: begin
                    if (mem_ack) begin
                        n.hold = mem_rdata[15:0];
                        n.st   = ST_TX_PUT;
                    end
                end
                ST_TX_PUT: adv = out_ready;
                default:   n.st = ST_IDLE;
            endcase
            if (adv) begin
                n.buf_addr = q.buf_addr + 32'd2;
                n.rem      = q.rem - WORD_BYTES;
                if (q.rem == WORD_BYTES) begin
                    if (q.eol) begin
                        n.st   = ST_IDLE;
                        n.done = 1'b1;
                        n.irq  = 1'b1;
                    end else begin
                        n.st      = ST_FETCH;
                        n.widx    = 2'd0;
                        n.cur_ptr = q.next_ptr;
                    end
                end else begin
                    n.st = q.rx ? ST_RX_GET : ST_TX_GET;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= n;
        end
    end

    assign busy = (q.st != ST_IDLE);
    assign done = q.done;
    assign irq  = q.irq;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !sw_reset) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R3
    AST_START_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sw_start && !sw_reset) |=> (mem_req && !mem_we)); // R2
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (!busy && !irq && !mem_req)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (irq && !busy)); // R9
    AST_REM_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.st != ST_FETCH) |-> !q.rem[0]); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !in_ready && !out_valid)); // R11
endmodule

// File: tb/dmac_chain_tb.sv
module dmac_chain_tb;
    localparam int LEN_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_first_we = 1'b0;
    logic [31:0] sw_first_ptr = '0;
    logic        sw_start = 1'b0;
    logic        sw_dir_rx = 1'b0;
    logic        sw_reset = 1'b0;
    logic        busy, done, irq, mem_req, mem_we, in_ready, out_valid;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, out_data;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_ready = 1'b0;

    always #4 clk = ~clk;

    dmac_chain #(.LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_first_we(sw_first_we), .sw_first_ptr(sw_first_ptr),
        .sw_start(sw_start), .sw_dir_rx(sw_dir_rx), .sw_reset(sw_reset),
        .busy(busy), .done(done), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
    );

    logic [15:0] hmem [0:8191];
    logic [31:0] rd_log [0:4095];
    logic [31:0] exp_rd [0:4095];
    logic [15:0] rx_words [0:2047];
    logic [15:0] tx_cap [0:2047];
    logic [15:0] exp_tx [0:2047];
    int lens [0:7];
    int bufs [0:7];
    int rd_n, exp_n, rx_n, rx_idx, tx_n, done_cnt, viol, total_w;
    int n_chk = 0, n_fail = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr;
    logic        pend_we;
    int          lat;
    logic [12:0] ha;

    function automatic int eff_len(input int l);
        if (l == 0) return 1 << LEN_W;
        return l + (l & 1);
    endfunction

    function automatic logic [31:0] daddr(input int i);
        return 32'h1000 + 32'h40 * ((i * 5) % 8);
    endfunction

    // memory, receive source and transmit sink, all driven away from the active edge
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (pend && (mem_addr != pend_addr || mem_we != pend_we)) viol++;
            if (!pend) begin
                pend = 1'b1; pend_addr = mem_addr; pend_we = mem_we; lat = $urandom % 3;
            end
            if (lat == 0) begin
                mem_ack = 1'b1;
                pend = 1'b0;
                ha = mem_addr[13:1];
                if (mem_we) begin
                    hmem[ha] = mem_wdata;
                end else begin
                    mem_rdata = {hmem[ha + 13'd1], hmem[ha]};
                    if (rd_n < 4096) rd_log[rd_n] = mem_addr;
                    rd_n++;
                end
            end else begin
                lat--;
            end
        end else begin
            pend = 1'b0;
        end
        if (rx_idx < rx_n && ($urandom % 4) != 0) begin
            in_valid = 1'b1; in_data = rx_words[rx_idx];
        end else begin
            in_valid = 1'b0; in_data = 16'($urandom);
        end
        if (in_valid && in_ready) rx_idx++;
        out_ready = ($urandom % 3) != 0;
        if (out_valid && out_ready && tx_n < 2048) begin
            tx_cap[tx_n] = out_data;
            tx_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic sample();
        @(negedge clk); #2;
    endtask

    task automatic put32(input logic [31:0] a, input logic [31:0] v);
        hmem[a[13:1]]         = v[15:0];
        hmem[a[13:1] + 13'd1] = v[31:16];
    endtask

    task automatic build_chain(input int nd, input bit rx);
        logic [31:0] d, lw, cw;
        int nw;
        exp_n = 0; total_w = 0;
        for (int i = 0; i < nd; i++) begin
            d  = daddr(i);
            lw = ($urandom & 32'hFFFF_FF00) | 32'(lens[i] & 8'hFF);
            cw = ($urandom & 32'hFFFF_FFFE) | 32'(i == nd - 1);
            put32(d, lw);
            put32(d + 4, cw);
            put32(d + 8, bufs[i]);
            put32(d + 12, (i == nd - 1) ? 32'h3F00 : daddr(i + 1));
            for (int k = 0; k < 4; k++) begin
                exp_rd[exp_n] = d + 32'(4 * k); exp_n++;
            end
            nw = eff_len(lens[i]) / 2;
            for (int k = 0; k <= nw; k++) begin
                hmem[13'((bufs[i] >> 1) + k)] = rx ? 16'hA5A5 : 16'($urandom);
            end
            for (int k = 0; k < nw; k++) begin
                if (rx) begin
                    rx_words[total_w + k] = 16'($urandom);
                    if (rx_words[total_w + k] == 16'hA5A5) rx_words[total_w + k] = 16'h0001;
                end else begin
                    exp_rd[exp_n] = 32'(bufs[i] + 2 * k); exp_n++;
                    exp_tx[total_w + k] = hmem[13'((bufs[i] >> 1) + k)];
                end
            end
            total_w += nw;
        end
        rx_n = rx ? total_w : 0;
        rx_idx = 0; tx_n = 0; rd_n = 0; done_cnt = 0; viol = 0;
    endtask

    task automatic start_chain(input bit rx);
        sw_first_ptr = daddr(0); sw_first_we = 1'b1;
        tick();
        sw_first_we = 1'b0; sw_start = 1'b1; sw_dir_rx = rx;
        tick();
        sw_start = 1'b0;
    endtask

    task automatic wait_idle();
        int w = 0;
        do begin
            sample(); w++;
        end while (busy && w < 20000);
    endtask

    task automatic finish_checks(input int nd, input bit rx, input string tag);
        int bad = 0, base = 0, nw;
        chk(!busy, "R9", "channel idle at end", busy, 0);
        chk(done_cnt == 1, "R9", "done pulse cycles", done_cnt, 1);
        chk(irq, "R9", "irq set", irq, 1);
        chk(rd_n == exp_n, "R8", "read count", rd_n, exp_n);
        for (int i = 0; i < exp_n && i < rd_n; i++) begin
            if (rd_log[i] != exp_rd[i]) begin
                if (bad == 0) chk(0, "R8", "read address order", rd_log[i], exp_rd[i]);
                bad++;
            end
        end
        chk(bad == 0, "R2", "fetch and buffer read sequence mismatches", bad, 0);
        chk(viol == 0, "R3", "request changed before ack", viol, 0);
        bad = 0;
        if (rx) begin
            for (int i = 0; i < nd; i++) begin
                nw = eff_len(lens[i]) / 2;
                for (int k = 0; k < nw; k++)
                    if (hmem[13'((bufs[i] >> 1) + k)] != rx_words[base + k]) bad++;
                chk(hmem[13'((bufs[i] >> 1) + nw)] == 16'hA5A5, "R5", "halfword past buffer untouched",
                    hmem[13'((bufs[i] >> 1) + nw)], 16'hA5A5);
                base += nw;
            end
            chk(bad == 0, tag, "R6 receive words in memory mismatches", bad, 0);
        end else begin
            chk(tx_n == total_w, tag, "R7 transmit word count", tx_n, total_w);
            for (int k = 0; k < total_w && k < tx_n; k++)
                if (tx_cap[k] != exp_tx[k]) bad++;
            chk(bad == 0, tag, "R7 transmit stream mismatches", bad, 0);
        end
        chk(!mem_req && !in_ready && !out_valid, "R11", "ports quiet when idle",
            {mem_req, in_ready, out_valid}, 0);
    endtask

    task automatic run_chain(input int nd, input bit rx, input bit poke, input string tag);
        build_chain(nd, rx);
        start_chain(rx);
        if (poke) begin
            repeat (6) tick();
            sw_first_ptr = 32'h3F00; sw_first_we = 1'b1;
            tick();
            sw_first_we = 1'b0; sw_start = 1'b1; sw_dir_rx = !rx;
            tick();
            sw_start = 1'b0;
        end
        wait_idle();
        finish_checks(nd, rx, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8192; i++) hmem[i] = '0;
        for (int i = 0; i < 8; i++) bufs[i] = 32'h2000 + 32'h200 * i + 2 * (i & 1);
        rx_n = 0; rx_idx = 0; tx_n = 0; rd_n = 0; done_cnt = 0; viol = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        sample();
        chk(!busy && !done && !irq && !mem_req, "R1", "reset state busy/done/irq/req",
            {busy, done, irq, mem_req}, 0);
        chk(!in_ready && !out_valid, "R11", "stream idle after reset", {in_ready, out_valid}, 0);

        lens[0] = 6;
        run_chain(1, 1'b1, 1'b0, "R6");
        repeat (5) tick();
        sample();
        chk(irq, "R9", "irq sticky while idle", irq, 1);

        lens[0] = 5; lens[1] = 1; lens[2] = 10;
        run_chain(3, 1'b0, 1'b0, "R5");
        lens[0] = 3; lens[1] = 7;
        run_chain(2, 1'b1, 1'b0, "R5");

        lens[0] = 0;
        run_chain(1, 1'b1, 1'b0, "R4");
        lens[0] = 2; lens[1] = 0;
        run_chain(2, 1'b0, 1'b0, "R4");

        lens[0] = 8; lens[1] = 8; lens[2] = 8;
        run_chain(3, 1'b0, 1'b1, "R2");

        // R10: abort in the middle of a long receive buffer
        sample();
        chk(irq, "R10", "irq set before reset command", irq, 1);
        lens[0] = 0;
        build_chain(1, 1'b1);
        start_chain(1'b1);
        repeat (30) tick();
        sw_reset = 1'b1;
        tick();
        sw_reset = 1'b0;
        rx_n = 0;
        sample();
        chk(!busy && !irq && !mem_req, "R10", "idle, flag cleared, no request after reset",
            {busy, irq, mem_req}, 0);
        chk(done_cnt == 0, "R10", "no completion from aborted run", done_cnt, 0);
        repeat (4) tick();
        lens[0] = 4;
        run_chain(1, 1'b1, 1'b0, "R10");

        for (int r = 0; r < 6; r++) begin
            int nd = 1 + ($urandom % 8);
            for (int i = 0; i < nd; i++)
                lens[i] = (($urandom % 8) == 0) ? 0 : 1 + ($urandom % 24);
            run_chain(nd, r[0], 1'b0, r[0] ? "R6" : "R7");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule